// File: doc/BRIEF.md
# VLIW ALU Execution Channel

This block runs one arithmetic-logic operation from a wide-issue instruction bundle. It gets a 32-bit operation word, two 64-bit source operands that earlier stages have already fetched, and the old contents of the destination register. It decodes the operation word and applies the selected function: bitwise logic, add or subtract, shift or rotate, or a 64-bit compare. One cycle later it presents the result, a tag that names the kind of target, the target index and the fault flags.

Nearly every operation comes as a pair of opcodes. The even opcode works on 32 bits and the odd opcode works on 64 bits. A 32-bit form computes on the low halves of the sources. It leaves the upper half of the old destination value in place, so that write-back can store all 64 bits. A compare does not write a register. It produces a single bit aimed at a predicate register. Decoding and execution sit between operand fetch and write-back, and the block handles neither of those.

Top module: `vliw_alu_lane`

## Requirements
- R1: Operation word fields: bits 30:24 are the opcode and bit 31 is the speculative flag, which appears on `res_spec`. For register results, `res_dest` carries bits 7:0 unchanged.
- R2: Opcodes 0x00..0x0b, taken in pairs, are AND, AND with inverted second source, OR, OR with inverted second source, XOR, and XOR with inverted second source. The inverted forms compute `a op ~b`.
- R3: Opcodes 0x10/0x11 compute a+b and opcodes 0x12/0x13 compute a-b, both modulo the operation width.
- R4: Opcodes 0x14/0x15 rotate left, 0x16/0x17 rotate right, 0x18/0x19 shift left, 0x1a/0x1b shift right logically and 0x1c/0x1d shift right arithmetically. The count is `b[4:0]` for 32-bit forms and `b[5:0]` for 64-bit forms.
- R5: An even opcode works on `a[31:0]` and `b[31:0]`. It drives result bits 31:0 and copies bits 63:32 from `dest_old`. An odd opcode produces all 64 bits.
- R6: Opcode 0x21 compares all 64 bits. The condition is word bits 7:5: 1 selects unsigned a <= b and 2 selects a == b. The result is 0 or 1 in bit 0 with kind predicate (`res_kind`=1), and `res_dest` = {3'b0, bits 4:0}. Any other condition value is illegal.
- R7: Opcode 0x40 raises `res_trap` with data 0, kind none (`res_kind`=2) and `res_dest` 0.
- R8: Every other opcode (including 0x0c, 0x0e, 0x0f, 0x1e, 0x1f) raises `res_illegal` with data 0, kind none (2) and `res_dest` 0. Register results use kind 0.
- R9: Results are registered. `res_vld` is `issue_vld` delayed by one cycle, and synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Operation word and operands are valid this cycle |
| syllable | input | 32 | Operation word |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand or shift count |
| dest_old | input | 64 | Current destination value, used for the upper half of 32-bit forms |
| res_vld | output | 1 | Result valid |
| res_data | output | 64 | Result value |
| res_kind | output | 2 | 0 register, 1 predicate, 2 none |
| res_dest | output | 8 | Register field or predicate index |
| res_spec | output | 1 | Speculative flag of the operation |
| res_illegal | output | 1 | Unimplemented opcode or compare condition |
| res_trap | output | 1 | Exception opcode |

## Verification
The assertions check, on every cycle, that the valid output tracks issue one cycle late and that a predicate result never has bits set above bit 0. They also check that a faulting operation carries no data and no target, that the two fault flags are never both set, and that a 32-bit form always hands back the upper half of the old destination. The arithmetic value of each function cannot be seen by a property. That includes rotate wrap-around, count masking, arithmetic sign fill, and the boundary between equal and unsigned-greater in compares. Only the bench shows these, by comparing against its own reference model across random and directed operation words.

// File: rtl/alu_lane_pkg.sv
package alu_lane_pkg;

  typedef enum logic [2:0] {
    FU_LOGIC = 3'd0,
    FU_ARITH = 3'd1,
    FU_SHIFT = 3'd2,
    FU_CMP   = 3'd3,
    FU_TRAP  = 3'd4,
    FU_BAD   = 3'd5
  } fu_e;

  typedef enum logic [1:0] {
    KIND_REG  = 2'd0,
    KIND_PRED = 2'd1,
    KIND_NONE = 2'd2
  } kind_e;

  // logic sub-op: {base[1:0], invert}; base 0 and, 1 or, 2 xor
  // shift sub-op: 0 rotl, 1 rotr, 2 shl, 3 shr, 4 sar
  typedef struct packed {
    fu_e        fu;
    logic       wide;
    logic [2:0] sub;
    logic       spec;
    logic [7:0] field_dst;
    logic [4:0] pred_idx;
  } dec_t;

  localparam logic [6:0] OPC_LOGIC_LAST = 7'h0b;
  localparam logic [6:0] OPC_ARITH_FIRST = 7'h10;
  localparam logic [6:0] OPC_ARITH_LAST  = 7'h13;
  localparam logic [6:0] OPC_SHIFT_FIRST = 7'h14;
  localparam logic [6:0] OPC_SHIFT_LAST  = 7'h1d;
  localparam logic [6:0] OPC_CMP_WIDE    = 7'h21;
  localparam logic [6:0] OPC_TRAP        = 7'h40;

  localparam logic [2:0] CMP_ULE = 3'd1;
  localparam logic [2:0] CMP_EQ  = 3'd2;

endpackage

// File: rtl/alu_lane_dec.sv
module alu_lane_dec
  import alu_lane_pkg::*;
(
  input  logic [31:0] syllable,
  output dec_t        dec
);
  logic [6:0] opc;
  logic [2:0] cond;
  logic [6:0] sh_rel;

  assign opc    = syllable[30:24];
  assign cond   = syllable[7:5];
  assign sh_rel = opc - OPC_SHIFT_FIRST;

  always_comb begin
    dec           = '0;
    dec.spec      = syllable[31];
    dec.field_dst = syllable[7:0];
    dec.pred_idx  = syllable[4:0];
    dec.wide      = opc[0];
    dec.fu        = FU_BAD;
    dec.sub       = 3'd0;
    if (opc <= OPC_LOGIC_LAST) begin
      dec.fu  = FU_LOGIC;
      dec.sub = {opc[3:2], opc[1]};
    end else if (opc >= OPC_ARITH_FIRST && opc <= OPC_ARITH_LAST) begin
      dec.fu  = FU_ARITH;
      dec.sub = {2'b00, opc[1]};
    end else if (opc >= OPC_SHIFT_FIRST && opc <= OPC_SHIFT_LAST) begin
      dec.fu  = FU_SHIFT;
      dec.sub = sh_rel[3:1];
    end else if (opc == OPC_CMP_WIDE) begin
      dec.wide = 1'b1;
      dec.sub  = cond;
      dec.fu   = (cond == CMP_ULE || cond == CMP_EQ) ? FU_CMP : FU_BAD;
    end else if (opc == OPC_TRAP) begin
      dec.fu = FU_TRAP;
    end
  end

  always_comb begin
    AST_DEC_SUB_RANGE: assert (dec.fu != FU_SHIFT || dec.sub <= 3'd4); // R4
  end
endmodule

// File: rtl/alu_lane_bitop.sv
module alu_lane_bitop #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    sub,
  output logic [DW-1:0] y
);
  logic [DW-1:0] b_eff;

  assign b_eff = sub[0] ? ~b : b;

  always_comb begin
    unique case (sub[2:1])
      2'd0:    y = a & b_eff;
      2'd1:    y = a | b_eff;
      2'd2:    y = a ^ b_eff;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_lane_addsub.sv
module alu_lane_addsub #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          subtract,
  output logic [DW-1:0] y
);
  logic [DW-1:0] b_eff;

  assign b_eff = subtract ? ~b : b;
  assign y     = a + b_eff + {{(DW-1){1'b0}}, subtract};
endmodule

// File: rtl/alu_lane_shift.sv
module alu_lane_shift #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    sub,
  input  logic          wide,
  output logic [DW-1:0] y
);
  localparam int HW  = DW / 2;
  localparam int SWD = $clog2(DW);
  localparam int SWH = $clog2(HW);

  logic [SWD-1:0]  amt_d;
  logic [SWH-1:0]  amt_h;
  logic [HW-1:0]   ah;
  logic [2*DW-1:0] dbl_l, dbl_r;
  logic [2*HW-1:0] hbl_l, hbl_r;
  logic [DW-1:0]   y_d;
  logic [HW-1:0]   y_h;

  assign amt_d = b[SWD-1:0];
  assign amt_h = b[SWH-1:0];
  assign ah    = a[HW-1:0];
  assign dbl_l = {a, a} << amt_d;
  assign dbl_r = {a, a} >> amt_d;
  assign hbl_l = {ah, ah} << amt_h;
  assign hbl_r = {ah, ah} >> amt_h;

  always_comb begin
    unique case (sub)
      3'd0:    y_d = dbl_l[2*DW-1:DW];
      3'd1:    y_d = dbl_r[DW-1:0];
      3'd2:    y_d = a << amt_d;
      3'd3:    y_d = a >> amt_d;
      3'd4:    y_d = DW'($signed(a) >>> amt_d);
      default: y_d = '0;
    endcase
    unique case (sub)
      3'd0:    y_h = hbl_l[2*HW-1:HW];
      3'd1:    y_h = hbl_r[HW-1:0];
      3'd2:    y_h = ah << amt_h;
      3'd3:    y_h = ah >> amt_h;
      3'd4:    y_h = HW'($signed(ah) >>> amt_h);
      default: y_h = '0;
    endcase
  end

  assign y = wide ? y_d : {{HW{1'b0}}, y_h};
endmodule

// File: rtl/vliw_alu_lane.sv
module vliw_alu_lane
  import alu_lane_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_vld,
  input  logic [31:0]   syllable,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] dest_old,
  output logic          res_vld,
  output logic [DW-1:0] res_data,
  output logic [1:0]    res_kind,
  output logic [7:0]    res_dest,
  output logic          res_spec,
  output logic          res_illegal,
  output logic          res_trap
);
  localparam int HW = DW / 2;

  dec_t          dec;
  logic [DW-1:0] y_logic, y_arith, y_shift, y_sel, y_next;
  logic          cmp_bit;
  kind_e         kind_next;
  logic [7:0]    dest_next;

  alu_lane_dec u_dec (
    .syllable (syllable),
    .dec      (dec)
  );

  alu_lane_bitop #(.DW(DW)) u_bitop (
    .a   (src_a),
    .b   (src_b),
    .sub (dec.sub),
    .y   (y_logic)
  );

  alu_lane_addsub #(.DW(DW)) u_addsub (
    .a        (src_a),
    .b        (src_b),
    .subtract (dec.sub[0]),
    .y        (y_arith)
  );

  alu_lane_shift #(.DW(DW)) u_shift (
    .a    (src_a),
    .b    (src_b),
    .sub  (dec.sub),
    .wide (dec.wide),
    .y    (y_shift)
  );

  assign cmp_bit = (dec.sub == CMP_EQ) ? (src_a == src_b) : (src_a <= src_b);

  always_comb begin
    y_sel     = '0;
    kind_next = KIND_NONE;
    dest_next = 8'd0;
    unique case (dec.fu)
      FU_LOGIC: begin y_sel = y_logic; kind_next = KIND_REG; dest_next = dec.field_dst; end
      FU_ARITH: begin y_sel = y_arith; kind_next = KIND_REG; dest_next = dec.field_dst; end
      FU_SHIFT: begin y_sel = y_shift; kind_next = KIND_REG; dest_next = dec.field_dst; end
      FU_CMP: begin
        y_sel     = {{(DW-1){1'b0}}, cmp_bit};
        kind_next = KIND_PRED;
        dest_next = {3'b000, dec.pred_idx};
      end
      default: ;
    endcase
    y_next = y_sel;
    if (kind_next == KIND_REG && !dec.wide)
      y_next = {dest_old[DW-1:HW], y_sel[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld     <= 1'b0;
      res_data    <= '0;
      res_kind    <= KIND_REG;
      res_dest    <= '0;
      res_spec    <= 1'b0;
      res_illegal <= 1'b0;
      res_trap    <= 1'b0;
    end else begin
      res_vld <= issue_vld;
      if (issue_vld) begin
        res_data    <= y_next;
        res_kind    <= kind_next;
        res_dest    <= dest_next;
        res_spec    <= dec.spec;
        res_illegal <= (dec.fu == FU_BAD);
        res_trap    <= (dec.fu == FU_TRAP);
      end
    end
  end

  AST_VLD_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_vld |=> res_vld); // R9
  AST_NO_VLD_WITHOUT_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> !res_vld); // R9
  AST_PRED_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_kind == KIND_PRED) |-> (res_data[DW-1:1] == '0)); // R6
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (res_vld && (res_illegal || res_trap)) |-> (res_data == '0 && res_kind == KIND_NONE && res_dest == 8'd0)); // R8
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> !(res_illegal && res_trap)); // R7
  AST_NARROW_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && (dec.fu == FU_LOGIC || dec.fu == FU_ARITH || dec.fu == FU_SHIFT) && !dec.wide)
    |=> (res_data[DW-1:HW] == $past(dest_old[DW-1:HW]))); // R5
endmodule

// File: tb/test_vliw_alu_lane.sv
module test_vliw_alu_lane;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue_vld;
  logic [31:0] syllable;
  logic [63:0] src_a, src_b, dest_old;
  logic        res_vld;
  logic [63:0] res_data;
  logic [1:0]  res_kind;
  logic [7:0]  res_dest;
  logic        res_spec, res_illegal, res_trap;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vliw_alu_lane i_vliw_alu_lane (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .syllable(syllable),
    .src_a(src_a), .src_b(src_b), .dest_old(dest_old),
    .res_vld(res_vld), .res_data(res_data), .res_kind(res_kind),
    .res_dest(res_dest), .res_spec(res_spec), .res_illegal(res_illegal),
    .res_trap(res_trap)
  );

  typedef struct packed {
    logic [63:0] d;
    logic [1:0]  k;
    logic [7:0]  dst;
    logic        ill;
    logic        trp;
  } exp_t;

  function automatic logic [31:0] rol32(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction
  function automatic logic [63:0] rol64(input logic [63:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (64 - n)));
  endfunction

  function automatic exp_t model(input logic [31:0] s, input logic [63:0] a,
                                 input logic [63:0] b, input logic [63:0] d);
    exp_t e;
    logic [6:0]  op = s[30:24];
    logic [31:0] a3 = a[31:0];
    logic [31:0] b3 = b[31:0];
    logic [31:0] r3 = 32'd0;
    logic [63:0] r6 = 64'd0;
    int n5 = int'(b[4:0]);
    int n6 = int'(b[5:0]);
    logic is_reg = 1'b1;
    e = '0;
    case (op)
      7'h00: r3 = a3 & b3;   7'h01: r6 = a & b;
      7'h02: r3 = a3 & ~b3;  7'h03: r6 = a & ~b;
      7'h04: r3 = a3 | b3;   7'h05: r6 = a | b;
      7'h06: r3 = a3 | ~b3;  7'h07: r6 = a | ~b;
      7'h08: r3 = a3 ^ b3;   7'h09: r6 = a ^ b;
      7'h0a: r3 = a3 ^ ~b3;  7'h0b: r6 = a ^ ~b;
      7'h10: r3 = a3 + b3;   7'h11: r6 = a + b;
      7'h12: r3 = a3 - b3;   7'h13: r6 = a - b;
      7'h14: r3 = rol32(a3, n5);               7'h15: r6 = rol64(a, n6);
      7'h16: r3 = rol32(a3, (32 - n5) % 32);   7'h17: r6 = rol64(a, (64 - n6) % 64);
      7'h18: r3 = a3 << n5;  7'h19: r6 = a << n6;
      7'h1a: r3 = a3 >> n5;  7'h1b: r6 = a >> n6;
      7'h1c: r3 = $signed(a3) >>> n5;  7'h1d: r6 = $signed(a) >>> n6;
      default: is_reg = 1'b0;
    endcase
    if (is_reg) begin
      e.k   = 2'd0;
      e.dst = s[7:0];
      e.d   = op[0] ? r6 : {d[63:32], r3};
    end else if (op == 7'h21 && (s[7:5] == 3'd1 || s[7:5] == 3'd2)) begin
      e.k   = 2'd1;
      e.dst = {3'b000, s[4:0]};
      e.d   = (s[7:5] == 3'd2) ? {63'd0, a == b} : {63'd0, a <= b};
    end else if (op == 7'h40) begin
      e.k = 2'd2; e.trp = 1'b1;
    end else begin
      e.k = 2'd2; e.ill = 1'b1;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [31:0] s);
    logic [6:0] op = s[30:24];
    if (op <= 7'h0b) return "R2";
    if (op >= 7'h10 && op <= 7'h13) return "R3";
    if (op >= 7'h14 && op <= 7'h1d) return "R4";
    if (op == 7'h21) return "R6";
    if (op == 7'h40) return "R7";
    return "R8";
  endfunction

  task automatic apply(input logic [31:0] s, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] d, input string tag);
    exp_t e;
    issue_vld = 1'b1; syllable = s; src_a = a; src_b = b; dest_old = d;
    e = model(s, a, b, d);
    @(negedge clk);
    n_run++;
    if (res_vld !== 1'b1 || res_data !== e.d || res_kind !== e.k || res_dest !== e.dst ||
        res_spec !== s[31] || res_illegal !== e.ill || res_trap !== e.trp) begin
      n_fail++;
      $display("FAIL %s syl=%h: got vld=%b data=%h kind=%0d dst=%h spec=%b ill=%b trap=%b, exp vld=1 data=%h kind=%0d dst=%h spec=%b ill=%b trap=%b",
               tag, s, res_vld, res_data, res_kind, res_dest, res_spec, res_illegal, res_trap,
               e.d, e.k, e.dst, s[31], e.ill, e.trp);
    end
  endtask

  function automatic logic [31:0] mk(input logic sp, input logic [6:0] op, input logic [7:0] lo);
    return {sp, op, 8'h00, 8'h00, lo} | (32'($urandom()) & 32'h00ff_ff00);
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] ops [0:22];
    void'($urandom(32'h5eed_0042));
    ops = '{7'h00,7'h01,7'h02,7'h03,7'h04,7'h05,7'h06,7'h07,7'h08,7'h09,7'h0a,7'h0b,
            7'h10,7'h11,7'h12,7'h13,7'h14,7'h15,7'h16,7'h17,7'h18,7'h19,7'h21};
    rst = 1'b1; issue_vld = 1'b0; syllable = '0; src_a = '0; src_b = '0; dest_old = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_run++; // R9 reset state
    if (res_vld !== 1'b0 || res_data !== 64'd0 || res_illegal !== 1'b0 || res_trap !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: got vld=%b data=%h ill=%b trap=%b, exp all zero", res_vld, res_data, res_illegal, res_trap);
    end

    // directed corner cases
    apply({1'b1, 7'h11, 16'h0, 8'h5a}, 64'd7, 64'd9, 64'hdead_beef_0000_0000, "R1");
    apply({1'b0, 7'h10, 16'h0, 8'h03}, 64'h1111_1111_ffff_ffff, 64'h1, 64'hcafe_f00d_1234_5678, "R5");
    apply({1'b0, 7'h12, 16'h0, 8'h04}, 64'h0, 64'h1, 64'h0, "R3");
    apply({1'b0, 7'h15, 16'h0, 8'h01}, 64'h8000_0000_0000_0001, 64'd0, 64'h0, "R4");
    apply({1'b0, 7'h15, 16'h0, 8'h01}, 64'h8000_0000_0000_0001, 64'd65, 64'h0, "R4");
    apply({1'b0, 7'h16, 16'h0, 8'h02}, 64'h0000_0000_0000_0003, 64'd33, 64'hffff_ffff_0000_0000, "R4");
    apply({1'b0, 7'h1d, 16'h0, 8'h02}, 64'h8000_0000_0000_0000, 64'd63, 64'h0, "R4");
    apply({1'b0, 7'h1c, 16'h0, 8'h02}, 64'h0000_0000_8000_0000, 64'd31, 64'h1234_5678_0000_0000, "R4");
    apply({1'b0, 7'h03, 16'h0, 8'h07}, 64'hffff_0000_ffff_0000, 64'h0f0f_0f0f_0f0f_0f0f, 64'h0, "R2");
    apply({1'b0, 7'h21, 16'h0, 3'd1, 5'd17}, 64'd5, 64'd5, 64'h0, "R6");
    apply({1'b0, 7'h21, 16'h0, 3'd1, 5'd17}, 64'd6, 64'd5, 64'h0, "R6");
    apply({1'b0, 7'h21, 16'h0, 3'd1, 5'd3}, 64'd1, 64'hffff_ffff_ffff_ffff, 64'h0, "R6");
    apply({1'b0, 7'h21, 16'h0, 3'd2, 5'd31}, 64'h42, 64'h42, 64'h0, "R6");
    apply({1'b0, 7'h21, 16'h0, 3'd0, 5'd2}, 64'h42, 64'h42, 64'h0, "R6");
    apply({1'b1, 7'h40, 16'h0, 8'h11}, 64'h9, 64'h9, 64'h9, "R7");
    apply({1'b0, 7'h0c, 16'h0, 8'h11}, 64'h9, 64'h9, 64'h9, "R8");
    apply({1'b0, 7'h1f, 16'h0, 8'h22}, 64'h9, 64'h9, 64'h9, "R8");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] s;
      logic [63:0] a, b;
      int pick = $urandom_range(0, 9);
      if (pick == 0)
        s = $urandom();
      else if (pick == 1)
        s = mk(1'($urandom()), 7'h21, {3'($urandom_range(0, 3)), 5'($urandom())});
      else if (pick == 2)
        s = mk(1'($urandom()), 7'($urandom_range(7'h18, 7'h1d)), 8'($urandom()));
      else
        s = mk(1'($urandom()), ops[$urandom_range(0, 22)], 8'($urandom()));
      a = {$urandom(), $urandom()};
      b = ($urandom_range(0, 5) == 0) ? a : {$urandom(), $urandom()};
      apply(s, a, b, {$urandom(), $urandom()}, tag_of(s));
    end

    issue_vld = 1'b0;
    @(negedge clk);
    n_run++; // R9 idle
    if (res_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 idle: got vld=%b, exp 0", res_vld);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule